// File: doc/BRIEF.md
# Self-Assigned I2C Address Claimer

This block lets a device on a shared I2C bus choose its own 7-bit address at start-up instead of carrying a configured one. It takes a candidate from a noisy entropy input (for example the low bits of an ADC sample) and rejects the reserved ranges. It then waits for the bus to be idle and briefly acts as a master. Each probe is an address-only write poll of the candidate.

An acknowledge means another device already answers at that address. In that case a fresh candidate is drawn and the count of probes starts again. A probe that goes unanswered is followed by a pseudo-random back-off before the next probe. After a set number of unanswered probes in a row, the candidate is taken as owned and `done` rises. From then on the block leaves the bus alone until reset.

The bus port is bit-level and open-drain. An enable output of 1 pulls the line low, and 0 releases it to high impedance. Clock synchronisation between masters and any data transfer are handled elsewhere.

Top module: `i2c_addr_claim`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0 (both lines released), and `done` and `busy` are 0.
- R2: A probe's START is issued only from a cycle in which `bus_idle` is 1. While `bus_idle` is held at 0, no START appears and `busy` stays 0.
- R3: The candidate is the 7-bit `entropy` value sampled while drawing. Values 0x00 to 0x07 and 0x78 to 0x7F are never used: the draw repeats every cycle until a legal value appears. The bounds 0x08 and 0x77 are legal.
- R4: A probe sends the following in order. First a START (SDA falls while SCL is high). Then the 8-bit frame {candidate, 0}, most significant bit first, with SDA changing only while SCL is low. Then one ACK clock with SDA released. Last a STOP (SDA rises while SCL is high). SCL and SDA never change in the same cycle.
- R5: If the target pulls SDA low in the ACK clock, the block draws a new candidate from `entropy` and clears its probe count. The next probe uses the new candidate.
- R6: After an unanswered probe that is not the last, the block waits between 1 and 256 bit periods, taken from an internal 16-bit LFSR. It then waits for `bus_idle` before the next probe. One bit period is 4×QDIV clock cycles.
- R7: After PROBES consecutive unanswered probes (default 3), `done` rises and `claimed_addr` holds the candidate. `done` then stays high until reset, and no further bus activity occurs.
- R8: `busy` is 1 exactly while a probe is in progress, from before START to the end of STOP. Both lines are released whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_idle | input | 1 | 1 when the shared bus is seen free |
| sda_in | input | 1 | Sampled level of the SDA line |
| entropy | input | 7 | Noisy bits used to form the candidate address |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| claimed_addr | output | 7 | Candidate address; the owned address once `done` is 1 |
| done | output | 1 | Address claimed |
| busy | output | 1 | Probe in progress on the bus |

## Verification
The assertions assume that `bus_idle` is a clean synchronous level. They also assume that `sda_in` reflects the wired-AND line that includes the block's own drive. The bench builds both lines from the enables and from a modelled target that pulls SDA only in the ACK clock after a matching write frame. `bus_idle` is changed only at block-visible moments (before a probe or right after a STOP), and `entropy` is changed only while no draw can be under way.

// File: rtl/i2c_addr_claim.sv
module i2c_addr_claim #(
  parameter int          QDIV   = 312,
  parameter int          PROBES = 3,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_idle,
  input  logic       sda_in,
  input  logic [6:0] entropy,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [6:0] claimed_addr,
  output logic       done,
  output logic       busy
);
  localparam int QW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam int PW = $clog2(PROBES + 1);

  typedef enum logic [2:0] {S_DRAW, S_WAIT, S_PROBE, S_BACK, S_DONE} st_t;

  st_t           st;
  logic [QW-1:0] qc;
  logic [3:0]    slot;
  logic [1:0]    q;
  logic [9:0]    boc;
  logic [PW-1:0] nprobe;
  logic          acked;
  logic [15:0]   lfsr;
  logic [6:0]    cand;

  wire tick  = (qc == QW'(QDIV - 1));
  wire legal = (entropy >= 7'h08) && (entropy <= 7'h77);
  wire fb    = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_DRAW;
      qc     <= '0;
      slot   <= '0;
      q      <= '0;
      boc    <= '0;
      nprobe <= '0;
      acked  <= 1'b0;
      lfsr   <= SEED;
      cand   <= 7'h08;
    end else begin
      lfsr <= {lfsr[14:0], fb};
      qc   <= ((st == S_PROBE || st == S_BACK) && !tick) ? qc + 1'b1 : '0;
      case (st)
        S_DRAW: if (legal) begin
          cand <= entropy;
          st   <= S_WAIT;
        end
        S_WAIT: if (bus_idle) begin
          st    <= S_PROBE;
          slot  <= '0;
          q     <= '0;
          acked <= 1'b0;
        end
        S_PROBE: if (tick) begin
          q <= q + 2'd1;
          if (slot == 4'd9 && q == 2'd2) acked <= !sda_in;
          if (q == 2'd3) begin
            if (slot == 4'd10) begin
              if (acked) begin
                nprobe <= '0;
                st     <= S_DRAW;
              end else if (nprobe == PW'(PROBES - 1)) begin
                st <= S_DONE;
              end else begin
                nprobe <= nprobe + 1'b1;
                boc    <= {lfsr[7:0], 2'b11};
                st     <= S_BACK;
              end
            end else begin
              slot <= slot + 4'd1;
            end
          end
        end
        S_BACK: if (tick) begin
          if (boc == '0) st <= S_WAIT;
          else boc <= boc - 10'd1;
        end
        default: ;
      endcase
    end
  end

  wire       hold = (q == 2'd0) && (slot != 4'd0);
  wire [3:0] es   = hold ? slot - 4'd1 : slot;
  wire [1:0] eq   = hold ? 2'd3 : q;
  wire [7:0] frame = {cand, 1'b0};
  wire [3:0] idx  = 4'd8 - es;

  logic sda_low;
  always_comb begin
    if (es == 4'd0)       sda_low = eq[1];
    else if (es <= 4'd8)  sda_low = !frame[idx[2:0]];
    else if (es == 4'd10) sda_low = (eq == 2'd1) || (eq == 2'd2);
    else                  sda_low = 1'b0;
  end

  assign busy         = (st == S_PROBE);
  assign scl_oe       = busy && (slot != 4'd0) && !q[1];
  assign sda_oe       = busy && sda_low;
  assign done         = (st == S_DONE);
  assign claimed_addr = cand;
endmodule

// File: rtl/i2c_addr_claim_chk.sv
module i2c_addr_claim_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_idle,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic       done,
  input logic [6:0] claimed_addr
);
  AST_START_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_idle)); // R2
  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (claimed_addr >= 7'h08 && claimed_addr <= 7'h77)); // R3
  AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(scl_oe) || $stable(sda_oe))); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(claimed_addr)); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R8
endmodule

bind i2c_addr_claim i2c_addr_claim_chk u_chk (.*);

// File: tb/i2c_addr_claim_bench.sv
module i2c_addr_claim_bench;
  localparam int Q = 4;
  localparam int BIT = 4 * Q;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_idle = 1'b0;
  logic [6:0] entropy = 7'h00;
  logic scl_oe, sda_oe, done, busy;
  logic [6:0] claimed_addr;
  logic ack_drv = 1'b0;

  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | ack_drv);

  i2c_addr_claim #(.QDIV(Q), .PROBES(3), .SEED(16'hACE1)) u_i2c_addr_claim (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .sda_in(sda_l),
    .entropy(entropy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .claimed_addr(claimed_addr), .done(done), .busy(busy));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_start = 0, n_stop = 0, n_ack = 0, bitc = 9;
  int stop_cyc = 0, gap_min = 1 << 30, gap_max = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] frames [16];
  logic [6:0] owner = 7'h00;
  logic owner_en = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung (actual cycle %0d, expected < 190000)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge sda_l) if (scl_l) begin
    if (n_stop > 0) begin
      if (cyc - stop_cyc < gap_min) gap_min = cyc - stop_cyc;
      if (cyc - stop_cyc > gap_max) gap_max = cyc - stop_cyc;
    end
    n_start++;
    bitc = 0;
  end
  always @(posedge scl_l) if (bitc < 8) begin
    sh = {sh[6:0], sda_l};
    bitc++;
  end
  always @(negedge scl_l) begin
    if (ack_drv) ack_drv = 1'b0;
    else if (bitc == 8) begin
      bitc = 9;
      if (owner_en && sh[7:1] == owner && !sh[0]) begin
        ack_drv = 1'b1;
        n_ack++;
      end
    end
  end
  always @(posedge sda_l) if (scl_l) begin
    if (n_stop < 16) frames[n_stop] = sh;
    n_stop++;
    stop_cyc = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [6:0] ent, input logic idle);
    rst_n = 1'b0;
    entropy = ent;
    bus_idle = idle;
    owner_en = 1'b0;
    repeat (4) @(posedge clk);
    n_start = 0; n_stop = 0; n_ack = 0; bitc = 9;
    gap_min = 1 << 30; gap_max = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && !done; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(7'h2A, 1'b0);
    chk(scl_oe == 1'b0, "R1 scl_oe", scl_oe, 0);
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    repeat (3000) @(posedge clk);
    @(negedge clk);
    chk(n_start == 0, "R2 no START while bus busy", n_start, 0);
    chk(busy == 1'b0, "R2 busy stays low", busy, 0);
  endtask

  task automatic t_free;
    do_reset(7'h2A, 1'b1);
    wait (n_start == 1);
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy during probe", busy, 1);
    wait_done(20000);
    chk(done == 1'b1, "R7 done", done, 1);
    chk(claimed_addr == 7'h2A, "R7 claimed_addr", claimed_addr, 7'h2A);
    chk(n_stop == 3, "R7 probe count", n_stop, 3);
    for (int i = 0; i < 3; i++)
      chk(frames[i] == 8'h54, "R4 frame {addr,W=0}", frames[i], 8'h54);
    chk(gap_min >= BIT, "R6 backoff min", gap_min, BIT);
    chk(gap_max <= 256 * BIT + 2 * BIT, "R6 backoff max", gap_max, 256 * BIT + 2 * BIT);
    repeat (3000) @(posedge clk);
    @(negedge clk);
    chk(n_start == 3, "R7 quiet after done", n_start, 3);
    chk(!scl_oe && !sda_oe && !busy, "R8 lines released after done", {scl_oe, sda_oe, busy}, 0);
    chk(done == 1'b1, "R7 done sticky", done, 1);
  endtask

  task automatic t_clash;
    do_reset(7'h2A, 1'b0);
    owner = 7'h2A;
    owner_en = 1'b1;
    bus_idle = 1'b1;
    wait (n_ack == 1);
    entropy = 7'h33;
    wait_done(20000);
    chk(claimed_addr == 7'h33, "R5 new candidate after clash", claimed_addr, 7'h33);
    chk(n_stop == 4, "R5 probe count restarted", n_stop, 4);
    chk(frames[0] == 8'h54, "R5 first frame", frames[0], 8'h54);
    chk(frames[1] == 8'h66, "R5 second frame", frames[1], 8'h66);
    chk(n_ack == 1, "R5 single clash", n_ack, 1);
  endtask

  task automatic t_reserved;
    do_reset(7'h05, 1'b1);
    repeat (2000) @(posedge clk);
    @(negedge clk);
    chk(n_start == 0 && !busy, "R3 low reserved rejected", n_start, 0);
    entropy = 7'h7A;
    repeat (2000) @(posedge clk);
    @(negedge clk);
    chk(n_start == 0 && !done, "R3 high reserved rejected", n_start, 0);
    entropy = 7'h08;
    wait_done(20000);
    chk(claimed_addr == 7'h08, "R3 lower bound accepted", claimed_addr, 7'h08);
    do_reset(7'h78, 1'b1);
    repeat (500) @(posedge clk);
    entropy = 7'h77;
    wait_done(20000);
    chk(claimed_addr == 7'h77, "R3 upper bound accepted", claimed_addr, 7'h77);
    chk(frames[0] == 8'hEE, "R3 upper bound frame", frames[0], 8'hEE);
  endtask

  task automatic t_idle_gate;
    do_reset(7'h40, 1'b1);
    wait (n_stop == 1);
    bus_idle = 1'b0;
    repeat (6000) @(posedge clk);
    @(negedge clk);
    chk(n_start == 1, "R2 held off after backoff", n_start, 1);
    chk(busy == 1'b0, "R2 busy low while waiting", busy, 0);
    bus_idle = 1'b1;
    wait_done(20000);
    chk(n_stop == 3 && claimed_addr == 7'h40, "R6 resumes after idle", n_stop, 3);
  endtask

  initial begin
    t_reset;
    t_free;
    t_clash;
    t_reserved;
    t_idle_gate;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule